// File: doc/BRIEF.md
# Direct-Mapped Cache Controller

This block is a single-level, direct-mapped cache between a processor that issues one word request at a time and a slower word-wide main memory. A 32-bit byte address is cut into a tag, a line index, a word-within-line select and a byte offset. A lookup compares the stored tag of the indexed line and checks its valid flag. A hit is answered from the line storage. A miss fetches the whole line from memory one word at a time, installs it, and then replays the stalled request, which now hits.

A parameter selects the store policy. In write-through mode every store also goes to memory before it is acknowledged. In write-back mode a store only marks the line dirty, and the old line is written back in full when a later miss needs its slot. Stores that miss always allocate the line first. A reset walks the line table and invalidates one entry per cycle. The processor side sees a stall flag during that walk and during every lookup, fill, eviction or store.

Top module: `dmCache`

## Requirements
- R1: Address fields are bits [1:0] byte (ignored), bits [WORD_SEL_W+1:2] word in line, the next INDEX_W bits line index, and the remaining upper bits tag. With the defaults (4-word lines, 8 lines) two addresses 128 bytes apart share a line and conflict, while different index values hold separate lines at the same time.
- R2: While reset is high and for 2^INDEX_W cycles after it falls, `cpuStall` is high and no request is taken. The walk clears one line per cycle, so every line reads as invalid afterwards, including lines that were valid before the reset.
- R3: A lookup hits only when the indexed line is valid and its tag matches. A read hit raises `rspValid` two clock edges after the edge that accepted the request and makes no memory access. `memReq` is never high while `cpuStall` is low.
- R4: A read miss issues 2^WORD_SEL_W memory reads, for words 0 upward of the missing line. It installs the line and returns the requested word from it.
- R5: A request is accepted on an edge where `cpuReq` is high and `cpuStall` is low. `cpuStall` is high from the next cycle until the cycle in which `rspValid` rises. Each request produces exactly one single-cycle `rspValid` pulse, and `rspData` is valid with it for reads.
- R6: A store that misses first fills the whole line from memory, then overwrites only the addressed word. Later reads of the other words return memory contents.
- R7: With WRITE_BACK=0, every store (hit or miss) performs exactly one memory word write of the store data to its address before it is acknowledged, and a miss never writes back the old line.
- R8: With WRITE_BACK=1, a store hit makes no memory access and leaves memory unchanged.
- R9: With WRITE_BACK=1, a miss on a valid dirty line first writes all 2^WORD_SEL_W words of the old line to their old addresses and then refills.
- R10: With WRITE_BACK=1, a miss on a clean line performs no memory writes.
- R11: While `memReq` is high and `memReady` is low, the next cycle keeps `memReq` high with `memAddr`, `memWe` and `memWdata` unchanged. A transfer completes in a cycle where both are high. For reads, `memRdata` is sampled in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, starts the invalidation walk |
| cpuReq | input | 1 | Processor request, taken when the block is not stalling |
| cpuWe | input | 1 | 1 = store, 0 = load |
| cpuAddr | input | ADDR_W | Byte address of the request |
| cpuWdata | input | DATA_W | Store data |
| cpuStall | output | 1 | High while the block cannot take a request |
| rspValid | output | 1 | One-cycle completion pulse per request |
| rspData | output | DATA_W | Load result, valid with rspValid |
| memReq | output | 1 | Memory transfer request |
| memWe | output | 1 | 1 = memory write |
| memAddr | output | ADDR_W | Word-aligned memory byte address |
| memWdata | output | DATA_W | Memory write data |
| memReady | input | 1 | Memory completes the current transfer |
| memRdata | input | DATA_W | Memory read data, valid with memReady |

## Verification
The bound checker watches the handshake rules on every cycle. It checks the stall window after reset, that stall follows each acceptance, that the response is a single pulse seen only when idle, that memory is quiet while idle, and that a pending memory request is held steady. The data-carrying behaviour can only be shown by the bench scenarios: the returned word, dirty eviction to the old address, write-allocate merging, the write-through update of memory, and the loss of valid lines across a reset. The bench shows these by comparing responses against a reference memory and by counting and inspecting the memory model's reads and writes.

// File: rtl/dmCachePkg.sv
`timescale 1ns/1ps
package dmCachePkg;

  typedef enum logic [2:0] {
    ST_CLEAR,
    ST_IDLE,
    ST_CHECK,
    ST_EVICT,
    ST_FILL,
    ST_STORE
  } ctrlState_t;

  // which address/data the memory port presents
  typedef enum logic [1:0] {
    SRC_FILL,
    SRC_EVICT,
    SRC_STORE
  } memSrc_t;

  // strobes from control to datapath
  typedef struct packed {
    logic    capture;    // latch processor request
    logic    hitWrite;   // write store word into line
    logic    fillWrite;  // write memory word into line
    logic    fillDone;   // install tag, set valid, clear dirty
    logic    markDirty;  // set dirty of indexed line
    logic    clearLine;  // invalidate line selected by walk index
    logic    respLoad;   // produce response pulse and data
    memSrc_t memSrc;
  } dpStrobe_t;

endpackage

// File: rtl/dmCacheCtrl.sv
`timescale 1ns/1ps
module dmCacheCtrl
  import dmCachePkg::*;
#(
  parameter int INDEX_W    = 3,
  parameter int WORD_SEL_W = 2,
  parameter bit WRITE_BACK = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cpuReq,
  input  logic                  hit,
  input  logic                  victimDirty,
  input  logic                  reqWrite,
  input  logic                  memReady,
  output dpStrobe_t             stb,
  output logic [INDEX_W-1:0]    walkIdx,
  output logic [WORD_SEL_W-1:0] wordCnt,
  output logic                  cpuStall,
  output logic                  memReq,
  output logic                  memWe
);

  localparam int LINES = 1 << INDEX_W;
  localparam int WORDS = 1 << WORD_SEL_W;

  ctrlState_t state, nextState;
  logic lastWord, lastLine;

  assign lastWord = (wordCnt == WORD_SEL_W'(WORDS - 1));
  assign lastLine = (walkIdx == INDEX_W'(LINES - 1));
  assign cpuStall = (state != ST_IDLE);

  always_comb begin
    stb        = '0;
    stb.memSrc = SRC_FILL;
    nextState  = state;
    memReq     = 1'b0;
    memWe      = 1'b0;
    case (state)
      ST_CLEAR: begin
        stb.clearLine = 1'b1;
        if (lastLine) nextState = ST_IDLE;
      end
      ST_IDLE: begin
        if (cpuReq) begin
          stb.capture = 1'b1;
          nextState   = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (hit) begin
          if (!reqWrite) begin
            stb.respLoad = 1'b1;
            nextState    = ST_IDLE;
          end else begin
            stb.hitWrite = 1'b1;
            if (WRITE_BACK) begin
              stb.markDirty = 1'b1;
              stb.respLoad  = 1'b1;
              nextState     = ST_IDLE;
            end else begin
              nextState = ST_STORE;
            end
          end
        end else if (WRITE_BACK && victimDirty) begin
          nextState = ST_EVICT;
        end else begin
          nextState = ST_FILL;
        end
      end
      ST_EVICT: begin
        memReq     = 1'b1;
        memWe      = 1'b1;
        stb.memSrc = SRC_EVICT;
        if (memReady && lastWord) nextState = ST_FILL;
      end
      ST_FILL: begin
        memReq     = 1'b1;
        stb.memSrc = SRC_FILL;
        if (memReady) begin
          stb.fillWrite = 1'b1;
          if (lastWord) begin
            stb.fillDone = 1'b1;
            nextState    = ST_CHECK;  // replay the stalled request
          end
        end
      end
      ST_STORE: begin
        memReq     = 1'b1;
        memWe      = 1'b1;
        stb.memSrc = SRC_STORE;
        if (memReady) begin
          stb.respLoad = 1'b1;
          nextState    = ST_IDLE;
        end
      end
      default: nextState = ST_CLEAR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_CLEAR;
      walkIdx <= '0;
      wordCnt <= '0;
    end else begin
      state <= nextState;
      if (state == ST_CLEAR) walkIdx <= walkIdx + 1'b1;
      if (state == ST_CHECK) begin
        wordCnt <= '0;
      end else if ((state == ST_EVICT || state == ST_FILL) && memReady) begin
        wordCnt <= wordCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/dmCacheDatapath.sv
`timescale 1ns/1ps
module dmCacheDatapath
  import dmCachePkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int INDEX_W    = 3,
  parameter int WORD_SEL_W = 2,
  parameter bit KEEP_DIRTY = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  dpStrobe_t             stb,
  input  logic [INDEX_W-1:0]    walkIdx,
  input  logic [WORD_SEL_W-1:0] wordCnt,
  input  logic                  cpuWe,
  input  logic [ADDR_W-1:0]     cpuAddr,
  input  logic [DATA_W-1:0]     cpuWdata,
  input  logic [DATA_W-1:0]     memRdata,
  output logic                  hit,
  output logic                  victimDirty,
  output logic                  reqWrite,
  output logic                  rspValid,
  output logic [DATA_W-1:0]     rspData,
  output logic [ADDR_W-1:0]     memAddr,
  output logic [DATA_W-1:0]     memWdata
);

  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int TAG_W  = ADDR_W - INDEX_W - WORD_SEL_W - BYTE_W;
  localparam int LINES  = 1 << INDEX_W;
  localparam int WORDS  = 1 << WORD_SEL_W;
  localparam int WADDR_W = ADDR_W - BYTE_W;

  // captured request (word address only; byte offset is not used)
  logic [WADDR_W-1:0] reqWordAddr;
  logic [DATA_W-1:0]  reqData;
  logic               reqWe;
  logic               unusedByteBits;

  logic [TAG_W-1:0]      reqTag;
  logic [INDEX_W-1:0]    reqIdx;
  logic [WORD_SEL_W-1:0] reqWord;

  logic [TAG_W-1:0]  tagMem  [LINES];
  logic [DATA_W-1:0] dataMem [LINES][WORDS];
  logic [LINES-1:0]  validBits;
  logic [LINES-1:0]  dirtyBits;

  assign unusedByteBits = ^cpuAddr[BYTE_W-1:0];

  assign reqTag   = reqWordAddr[WADDR_W-1 -: TAG_W];
  assign reqIdx   = reqWordAddr[WORD_SEL_W +: INDEX_W];
  assign reqWord  = reqWordAddr[WORD_SEL_W-1:0];
  assign reqWrite = reqWe;

  always_ff @(posedge clk) begin
    if (stb.capture) begin
      reqWordAddr <= cpuAddr[ADDR_W-1:BYTE_W];
      reqData     <= cpuWdata;
      reqWe       <= cpuWe;
    end
  end

  // line storage: fill words come from memory, store words from the request
  always_ff @(posedge clk) begin
    if (stb.fillWrite) dataMem[reqIdx][wordCnt] <= memRdata;
    if (stb.hitWrite)  dataMem[reqIdx][reqWord] <= reqData;
    if (stb.fillDone)  tagMem[reqIdx]           <= reqTag;
  end

  always_ff @(posedge clk) begin
    if (stb.clearLine) begin
      validBits[walkIdx] <= 1'b0;
    end else if (stb.fillDone) begin
      validBits[reqIdx] <= 1'b1;
    end
  end

  // dirty tracking exists only for the write-back variant
  generate
    if (KEEP_DIRTY) begin : gDirty
      always_ff @(posedge clk) begin
        if (stb.clearLine) begin
          dirtyBits[walkIdx] <= 1'b0;
        end else if (stb.fillDone) begin
          dirtyBits[reqIdx] <= 1'b0;
        end else if (stb.markDirty) begin
          dirtyBits[reqIdx] <= 1'b1;
        end
      end
    end else begin : gNoDirty
      assign dirtyBits = '0;
    end
  endgenerate

  assign hit         = validBits[reqIdx] && (tagMem[reqIdx] == reqTag);
  assign victimDirty = validBits[reqIdx] && dirtyBits[reqIdx];

  always_comb begin
    case (stb.memSrc)
      SRC_EVICT: memAddr = {tagMem[reqIdx], reqIdx, wordCnt, {BYTE_W{1'b0}}};
      SRC_STORE: memAddr = {reqWordAddr, {BYTE_W{1'b0}}};
      default:   memAddr = {reqTag, reqIdx, wordCnt, {BYTE_W{1'b0}}};
    endcase
  end

  assign memWdata = (stb.memSrc == SRC_STORE) ? reqData : dataMem[reqIdx][wordCnt];

  always_ff @(posedge clk) begin
    if (rst) begin
      rspValid <= 1'b0;
    end else begin
      rspValid <= stb.respLoad;
    end
    if (stb.respLoad) rspData <= dataMem[reqIdx][reqWord];
  end

endmodule

// File: rtl/dmCache.sv
`timescale 1ns/1ps
module dmCache
  import dmCachePkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int INDEX_W    = 3,
  parameter int WORD_SEL_W = 2,
  parameter bit WRITE_BACK = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuStall,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memReady,
  input  logic [DATA_W-1:0] memRdata
);

  dpStrobe_t             stb;
  logic [INDEX_W-1:0]    walkIdx;
  logic [WORD_SEL_W-1:0] wordCnt;
  logic                  hit, victimDirty, reqWrite;

  dmCacheCtrl #(
    .INDEX_W   (INDEX_W),
    .WORD_SEL_W(WORD_SEL_W),
    .WRITE_BACK(WRITE_BACK)
  ) uCtrl (
    .clk        (clk),
    .rst        (rst),
    .cpuReq     (cpuReq),
    .hit        (hit),
    .victimDirty(victimDirty),
    .reqWrite   (reqWrite),
    .memReady   (memReady),
    .stb        (stb),
    .walkIdx    (walkIdx),
    .wordCnt    (wordCnt),
    .cpuStall   (cpuStall),
    .memReq     (memReq),
    .memWe      (memWe)
  );

  dmCacheDatapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .INDEX_W   (INDEX_W),
    .WORD_SEL_W(WORD_SEL_W),
    .KEEP_DIRTY(WRITE_BACK)
  ) uDp (
    .clk        (clk),
    .rst        (rst),
    .stb        (stb),
    .walkIdx    (walkIdx),
    .wordCnt    (wordCnt),
    .cpuWe      (cpuWe),
    .cpuAddr    (cpuAddr),
    .cpuWdata   (cpuWdata),
    .memRdata   (memRdata),
    .hit        (hit),
    .victimDirty(victimDirty),
    .reqWrite   (reqWrite),
    .rspValid   (rspValid),
    .rspData    (rspData),
    .memAddr    (memAddr),
    .memWdata   (memWdata)
  );

endmodule

// File: rtl/dmCacheChecker.sv
`timescale 1ns/1ps
module dmCacheChecker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cpuReq,
  input logic              cpuStall,
  input logic              rspValid,
  input logic              memReq,
  input logic              memWe,
  input logic              memReady,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memWdata
);

  localparam int CNT_W = $clog2(LINES) + 1;

  // edges since reset fell, saturating at LINES
  logic [CNT_W-1:0] clrCnt;
  always_ff @(posedge clk) begin
    if (rst) begin
      clrCnt <= '0;
    end else if (clrCnt != CNT_W'(LINES)) begin
      clrCnt <= clrCnt + 1'b1;
    end
  end

  a_r2_walk_stalls: assert property (@(posedge clk) disable iff (rst)
    (clrCnt < CNT_W'(LINES)) |-> cpuStall);

  a_r5_accept_stalls: assert property (@(posedge clk) disable iff (rst)
    (cpuReq && !cpuStall) |=> cpuStall);

  a_r5_resp_when_idle: assert property (@(posedge clk) disable iff (rst)
    rspValid |-> !cpuStall);

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rspValid |=> !rspValid);

  a_r3_idle_no_mem: assert property (@(posedge clk) disable iff (rst)
    !cpuStall |-> !memReq);

  a_r11_req_hold: assert property (@(posedge clk) disable iff (rst)
    (memReq && !memReady) |=>
      (memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata)));

endmodule

bind dmCache dmCacheChecker #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .LINES (1 << INDEX_W)
) uChk (
  .clk     (clk),
  .rst     (rst),
  .cpuReq  (cpuReq),
  .cpuStall(cpuStall),
  .rspValid(rspValid),
  .memReq  (memReq),
  .memWe   (memWe),
  .memReady(memReady),
  .memAddr (memAddr),
  .memWdata(memWdata)
);

// File: tb/sim_dmCache.sv
`timescale 1ns/1ps
module simMem #(
  parameter int LAT = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req,
  input  logic        we,
  input  logic [31:0] addr,
  input  logic [31:0] wdata,
  output logic        ready,
  output logic [31:0] rdata,
  output int          rdCount,
  output int          wrCount
);
  logic [31:0] store [1024];
  int waitCnt = 0;

  initial begin
    rdCount = 0;
    wrCount = 0;
    for (int i = 0; i < 1024; i++) store[i] = 32'h5000_0000 + i * 7;
  end

  assign ready = req && (waitCnt == LAT);
  assign rdata = store[addr[11:2]];

  always @(posedge clk) begin
    if (rst) begin
      waitCnt <= 0;
    end else if (req) begin
      if (ready) begin
        waitCnt <= 0;
        if (we) begin
          store[addr[11:2]] <= wdata;
          wrCount <= wrCount + 1;
        end else begin
          rdCount <= rdCount + 1;
        end
      end else begin
        waitCnt <= waitCnt + 1;
      end
    end
  end
endmodule

module sim_dmCache;
  localparam int LINES = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        req0 = 0, we0 = 0, req1 = 0, we1 = 0;
  logic [31:0] addr0 = 0, wdata0 = 0, addr1 = 0, wdata1 = 0;
  logic        stall0, rv0, mReq0, mWe0, mReady0;
  logic        stall1, rv1, mReq1, mWe1, mReady1;
  logic [31:0] rdata0, mAddr0, mWdata0, mRdata0;
  logic [31:0] rdata1, mAddr1, mWdata1, mRdata1;
  int          rdCnt0, wrCnt0, rdCnt1, wrCnt1;

  dmCache #(.WRITE_BACK(1'b1)) u0 (
    .clk(clk), .rst(rst), .cpuReq(req0), .cpuWe(we0), .cpuAddr(addr0), .cpuWdata(wdata0),
    .cpuStall(stall0), .rspValid(rv0), .rspData(rdata0),
    .memReq(mReq0), .memWe(mWe0), .memAddr(mAddr0), .memWdata(mWdata0),
    .memReady(mReady0), .memRdata(mRdata0));

  dmCache #(.WRITE_BACK(1'b0)) u1 (
    .clk(clk), .rst(rst), .cpuReq(req1), .cpuWe(we1), .cpuAddr(addr1), .cpuWdata(wdata1),
    .cpuStall(stall1), .rspValid(rv1), .rspData(rdata1),
    .memReq(mReq1), .memWe(mWe1), .memAddr(mAddr1), .memWdata(mWdata1),
    .memReady(mReady1), .memRdata(mRdata1));

  simMem #(.LAT(2)) mem0 (.clk(clk), .rst(rst), .req(mReq0), .we(mWe0), .addr(mAddr0),
    .wdata(mWdata0), .ready(mReady0), .rdata(mRdata0), .rdCount(rdCnt0), .wrCount(wrCnt0));
  simMem #(.LAT(2)) mem1 (.clk(clk), .rst(rst), .req(mReq1), .we(mWe1), .addr(mAddr1),
    .wdata(mWdata1), .ready(mReady1), .rdata(mRdata1), .rdCount(rdCnt1), .wrCount(wrCnt1));

  int checks = 0;
  int errors = 0;

  // processor-visible reference memories
  logic [31:0] ref0 [1024];
  logic [31:0] ref1 [1024];

  typedef struct {
    bit          sel;
    bit          isRead;
    logic [31:0] data;
    string       rq;
  } expItem_t;
  expItem_t expQ[$];

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic popCheck(input bit sel, input logic [31:0] got);
    expItem_t it;
    checks++;
    if (expQ.size() == 0) begin
      errors++;
      $display("FAIL R5 unexpected response sel=%0d actual=%h expected=none", sel, got);
    end else begin
      it = expQ.pop_front();
      if (it.sel != sel) begin
        errors++;
        $display("FAIL R5 response from wrong cache actual=%0d expected=%0d", sel, it.sel);
      end else if (it.isRead && got !== it.data) begin
        errors++;
        $display("FAIL %s read data actual=%h expected=%h", it.rq, got, it.data);
      end
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rv0) popCheck(1'b0, rdata0);
    if (rv1) popCheck(1'b1, rdata1);
  end

  // driver: one request, waits for its response, returns latency in cycles
  task automatic doReq(input bit sel, input bit we, input logic [31:0] addr,
                       input logic [31:0] data, input string rq, output int lat);
    expItem_t it;
    bit stallBad;
    while (sel ? stall1 : stall0) @(negedge clk);
    it.sel = sel; it.isRead = !we; it.rq = rq;
    it.data = sel ? ref1[addr[11:2]] : ref0[addr[11:2]];
    if (we) begin
      if (sel) ref1[addr[11:2]] = data; else ref0[addr[11:2]] = data;
    end
    expQ.push_back(it);
    if (sel) begin req1 = 1; we1 = we; addr1 = addr; wdata1 = data; end
    else     begin req0 = 1; we0 = we; addr0 = addr; wdata0 = data; end
    @(negedge clk);
    req0 = 0; req1 = 0;
    lat = 1;
    stallBad = 0;
    while (!(sel ? rv1 : rv0) && lat < 300) begin
      if (!(sel ? stall1 : stall0)) stallBad = 1;
      @(negedge clk);
      lat++;
    end
    chk("R5", "stall held until response", {31'd0, stallBad}, 32'd0);
  endtask

  task automatic applyReset();
    rst = 1;
    repeat (3) @(negedge clk);
    chk("R2", "stall during reset", {31'd0, stall0}, 32'd1);
    chk("R5", "no response during reset", {31'd0, rv0}, 32'd0);
    rst = 0;
    repeat (LINES - 1) @(negedge clk);
    chk("R2", "stall on last walk cycle", {31'd0, stall0}, 32'd1);
    @(negedge clk);
    chk("R2", "idle after walk", {31'd0, stall0}, 32'd0);
  endtask

  initial begin
    #(4 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int lat, r, w;
    for (int i = 0; i < 1024; i++) begin
      ref0[i] = 32'h5000_0000 + i * 7;
      ref1[i] = 32'h5000_0000 + i * 7;
    end
    applyReset();

    // ---------- write-back cache (u0) ----------
    r = rdCnt0; w = wrCnt0;
    doReq(0, 0, 32'h000, 0, "R4", lat);               // cold read miss
    chk("R4", "line fill reads", rdCnt0 - r, 4);

    r = rdCnt0;
    doReq(0, 0, 32'h00E, 0, "R1", lat);               // word 3, byte bits ignored
    chk("R3", "read hit latency", lat, 2);
    chk("R3", "read hit no memory read", rdCnt0 - r, 0);

    r = rdCnt0; w = wrCnt0;
    doReq(0, 1, 32'h004, 32'hDEAD_0001, "R8", lat);   // write hit
    chk("R8", "write hit no memory write", wrCnt0 - w, 0);
    chk("R8", "memory unchanged after write hit", mem0.store[1], 32'h5000_0007);
    doReq(0, 0, 32'h004, 0, "R8", lat);               // read back dirty word

    r = rdCnt0; w = wrCnt0;
    doReq(0, 0, 32'h080, 0, "R1", lat);               // conflict, dirty victim
    chk("R9", "dirty eviction writes", wrCnt0 - w, 4);
    chk("R9", "evicted word at old address", mem0.store[1], 32'hDEAD_0001);
    chk("R4", "refill reads after eviction", rdCnt0 - r, 4);

    r = rdCnt0; w = wrCnt0;
    doReq(0, 0, 32'h100, 0, "R10", lat);              // conflict, clean victim
    chk("R10", "clean miss no writes", wrCnt0 - w, 0);
    chk("R10", "clean miss fill reads", rdCnt0 - r, 4);

    r = rdCnt0; w = wrCnt0;
    doReq(0, 1, 32'h238, 32'hBEEF_0002, "R6", lat);   // write miss, allocate
    chk("R6", "write miss fill reads", rdCnt0 - r, 4);
    chk("R6", "write miss no memory write", wrCnt0 - w, 0);
    doReq(0, 0, 32'h238, 0, "R6", lat);
    chk("R6", "merged word hits", lat, 2);
    doReq(0, 0, 32'h230, 0, "R6", lat);               // neighbour from memory

    r = rdCnt0;
    doReq(0, 0, 32'h010, 0, "R1", lat);               // index 1
    doReq(0, 0, 32'h100, 0, "R1", lat);               // index 0 still resident
    chk("R1", "separate index coexists", lat, 2);
    chk("R1", "reads for index 1 only", rdCnt0 - r, 4);

    // ---------- reset invalidates lines ----------
    applyReset();
    r = rdCnt0;
    doReq(0, 0, 32'h100, 0, "R2", lat);
    chk("R2", "line invalid after reset", rdCnt0 - r, 4);

    // ---------- write-through cache (u1) ----------
    r = rdCnt1; w = wrCnt1;
    doReq(1, 0, 32'h040, 0, "R4", lat);
    chk("R4", "fill reads write-through", rdCnt1 - r, 4);

    r = rdCnt1; w = wrCnt1;
    doReq(1, 1, 32'h044, 32'h5A5A_0003, "R7", lat);   // write hit
    chk("R7", "write hit one memory write", wrCnt1 - w, 1);
    chk("R7", "write hit no memory read", rdCnt1 - r, 0);
    chk("R7", "memory updated on store", mem1.store[32'h11], 32'h5A5A_0003);

    r = rdCnt1; w = wrCnt1;
    doReq(1, 1, 32'h3C4, 32'h7777_0004, "R6", lat);   // write miss, same line slot
    chk("R6", "write-through allocate reads", rdCnt1 - r, 4);
    chk("R7", "write miss single write, no writeback", wrCnt1 - w, 1);
    chk("R7", "memory holds miss store", mem1.store[32'hF1], 32'h7777_0004);
    doReq(1, 0, 32'h3C4, 0, "R6", lat);

    r = rdCnt1; w = wrCnt1;
    doReq(1, 0, 32'h044, 0, "R7", lat);               // refetched from memory
    chk("R7", "conflict miss no writes", wrCnt1 - w, 0);

    repeat (3) @(negedge clk);
    chk("R5", "all responses returned", expQ.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule